// File: doc/BRIEF.md
# Sideband Claim Bus Arbiter

This controller decides whether the local host may drive a two-wire bus that several hosts share. It does not use bit-level multi-master arbitration. Each host has its own claim wire. A claim wire is active low and pulled up, so a host that has released its claim reads high. When local logic raises a request, the block pulls its own claim wire low and waits a settle interval so that the other hosts can see the change. It then looks at the claim wires of the other hosts.

If none of the other hosts is claiming, the bus is granted at once. If another host is claiming, the block keeps its claim asserted and waits a longer interval, then checks again. If the contention is still present, the block releases its claim and waits a back-off interval. It then starts over by asserting its claim again. A deadline timer starts at the first claim assertion. When it expires, the attempt is abandoned with a one-cycle fail pulse. All durations are whole numbers of clock cycles, set by parameters.

Top module: `bus_claim_arb`

## Requirements
- R1: While reset is active and in the first cycle after reset, `claim_no` is 1, `grant_o` is 0 and `fail_o` is 0.
- R2: A request accepted in idle pulls `claim_no` low at the next clock edge. `grant_o` stays low for at least SETT_CYC cycles of asserted claim.
- R3: When every peer input reads 1 at the end of the settle interval, `grant_o` rises exactly SETT_CYC edges after the edge that accepted the request, and `claim_no` stays low while `grant_o` is high.
- R4: Bit i of `peer_claim_ni` is the claim of peer i. A 0 on any bit is contention. On contention at the end of settle, the claim stays asserted for HOLD_CYC further cycles. If all peers read 1 at the end of that interval, the grant follows (at SETT_CYC+HOLD_CYC edges after acceptance).
- R5: If contention persists after the hold interval, `claim_no` goes high for BACK_CYC cycles. The claim is then asserted again and a new settle interval begins.
- R6: DEAD_CYC edges after the accepting edge, a claim attempt that has not been granted ends. `fail_o` is high for exactly one cycle, and `claim_no` is 1 and `grant_o` is 0 during that cycle. The deadline wins over a grant or restart that falls on the same edge.
- R7: Peer inputs pass through a two-stage synchronizer. A change driven on a peer input becomes visible to the decision logic only after two clock edges.
- R8: A release input, while granted or during any claim phase, returns the block to idle at the next edge. At that edge `claim_no` goes to 1 and `grant_o` to 0, and no fail pulse is produced.
- R9: A request that arrives while the grant is held has no effect: `grant_o` stays 1 and `claim_no` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Local request for the bus |
| rel_i | input | 1 | Local release of the bus or abort of an attempt |
| peer_claim_ni | input | NUM_PEERS | Claim wires of the other hosts, active low, asynchronous |
| claim_no | output | 1 | Own claim wire, active low |
| grant_o | output | 1 | Bus is owned by the local host |
| fail_o | output | 1 | One-cycle pulse when the deadline ends an attempt |

## Verification
The assertions assume that `req_i` and `rel_i` are synchronous to `clk_i`. They also assume that the parameters meet SETT_CYC, HOLD_CYC and BACK_CYC of at least 1 and DEAD_CYC of at least 2. The peer inputs may change at any time because of the synchronizer. The bench drives every input one time step after a rising edge and holds it for at least one full cycle. Peer patterns are set several cycles before a request, except in the tests that target synchronizer latency, where the cycle of the change is picked on purpose.

// File: rtl/bus_claim_pkg.sv
package bus_claim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HOLD,
    ST_BACKOFF,
    ST_OWN
  } arb_state_e;
endpackage

// File: rtl/claim_sync.sv
module claim_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_ni,
  output logic [W-1:0] sync_no
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    // reset to released (pull-up) level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= async_ni[i];
        s2_q <= s1_q;
      end
    end
    assign sync_no[i] = s2_q;
  end
endmodule

// File: rtl/claim_timer.sv
module claim_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/bus_claim_arb.sv
module bus_claim_arb
  import bus_claim_pkg::*;
#(
  parameter int NUM_PEERS = 2,
  parameter int SETT_CYC  = 1000,
  parameter int HOLD_CYC  = 200000,
  parameter int BACK_CYC  = 200000,
  parameter int DEAD_CYC  = 2000000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 rel_i,
  input  logic [NUM_PEERS-1:0] peer_claim_ni,
  output logic                 claim_no,
  output logic                 grant_o,
  output logic                 fail_o
);
  localparam int PH_MAX = (SETT_CYC > HOLD_CYC) ?
                          ((SETT_CYC > BACK_CYC) ? SETT_CYC : BACK_CYC) :
                          ((HOLD_CYC > BACK_CYC) ? HOLD_CYC : BACK_CYC);
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam int DL_W = $clog2(DEAD_CYC + 1);

  arb_state_e state_q, state_d;
  logic [NUM_PEERS-1:0] peer_sync_n;
  logic contend;
  logic ph_load, ph_done, dl_load, dl_done, fail_d;
  logic [PH_W-1:0] ph_val;
  logic claim_nq, grant_q, fail_q;

  claim_sync #(.W(NUM_PEERS)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_ni(peer_claim_ni),
    .sync_no (peer_sync_n)
  );

  assign contend = ~&peer_sync_n;

  claim_timer #(.W(PH_W)) phase_tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ph_load),
    .load_val_i(ph_val),
    .done_o    (ph_done)
  );

  claim_timer #(.W(DL_W)) dead_tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (dl_load),
    .load_val_i(DL_W'(DEAD_CYC - 1)),
    .done_o    (dl_done)
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    dl_load = 1'b0;
    fail_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && !rel_i) begin
          state_d = ST_SETTLE;
          ph_load = 1'b1;
          ph_val  = PH_W'(SETT_CYC - 1);
          dl_load = 1'b1;
        end
      end
      ST_SETTLE, ST_HOLD, ST_BACKOFF: begin
        if (rel_i) begin
          state_d = ST_IDLE;
        end else if (dl_done) begin
          // deadline outranks any phase outcome
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else if (ph_done) begin
          if (state_q == ST_BACKOFF) begin
            state_d = ST_SETTLE;
            ph_load = 1'b1;
            ph_val  = PH_W'(SETT_CYC - 1);
          end else if (!contend) begin
            state_d = ST_OWN;
          end else if (state_q == ST_SETTLE) begin
            state_d = ST_HOLD;
            ph_load = 1'b1;
            ph_val  = PH_W'(HOLD_CYC - 1);
          end else begin
            state_d = ST_BACKOFF;
            ph_load = 1'b1;
            ph_val  = PH_W'(BACK_CYC - 1);
          end
        end
      end
      ST_OWN: begin
        if (rel_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      claim_nq <= 1'b1;
      grant_q  <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      claim_nq <= !(state_d == ST_SETTLE || state_d == ST_HOLD || state_d == ST_OWN);
      grant_q  <= (state_d == ST_OWN);
      fail_q   <= fail_d;
    end
  end

  assign claim_no = claim_nq;
  assign grant_o  = grant_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/bus_claim_arb_chk.sv
module bus_claim_arb_chk #(
  parameter int SETT_CYC = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic rel_i,
  input logic claim_no,
  input logic grant_o,
  input logic fail_o
);
  logic [31:0] run_q;

  // cycles of continuous own claim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (claim_no)       run_q <= '0;
    else if (run_q != '1)    run_q <= run_q + 1'b1;
  end

  AST_SETTLE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> run_q >= 32'(SETT_CYC)); // R2
  AST_GRANT_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !claim_no); // R3
  AST_FAIL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o); // R6
  AST_FAIL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> claim_no && !grant_o); // R6
  AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o && rel_i |=> !grant_o && claim_no && !fail_o); // R8
  AST_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o && req_i && !rel_i |=> grant_o && !claim_no); // R9
endmodule

bind bus_claim_arb bus_claim_arb_chk #(.SETT_CYC(SETT_CYC)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .rel_i   (rel_i),
  .claim_no(claim_no),
  .grant_o (grant_o),
  .fail_o  (fail_o)
);

// File: tb/bus_claim_arb_tb_top.sv
module bus_claim_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 3;
  localparam int SETT = 4;
  localparam int HOLD = 10;
  localparam int BACK = 6;
  localparam int DEAD = 60;

  typedef struct packed {
    logic [NP-1:0] peers;
    logic          exp_grant;
    logic [15:0]   exp_at;
  } vec_t;

  // exp_at: loop index (edges after the accepting one, plus 1) where outcome shows
  localparam vec_t VECS [5] = '{
    '{peers: 3'b111, exp_grant: 1'b1, exp_at: 16'(SETT + 1)},
    '{peers: 3'b110, exp_grant: 1'b0, exp_at: 16'(DEAD + 1)},
    '{peers: 3'b011, exp_grant: 1'b0, exp_at: 16'(DEAD + 1)},
    '{peers: 3'b101, exp_grant: 1'b0, exp_at: 16'(DEAD + 1)},
    '{peers: 3'b000, exp_grant: 1'b0, exp_at: 16'(DEAD + 1)}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic rel_i = 1'b0;
  logic [NP-1:0] peer_claim_ni = '1;
  logic claim_no, grant_o, fail_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_claim_arb #(
    .NUM_PEERS(NP), .SETT_CYC(SETT), .HOLD_CYC(HOLD),
    .BACK_CYC(BACK), .DEAD_CYC(DEAD)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .rel_i        (rel_i),
    .peer_claim_ni(peer_claim_ni),
    .claim_no     (claim_no),
    .grant_o      (grant_o),
    .fail_o       (fail_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // request accepted at the next edge; returns just after it
  task automatic start_req();
    req_i = 1'b1;
    adv(1);
    req_i = 1'b0;
  endtask

  task automatic do_release();
    rel_i = 1'b1;
    adv(1);
    rel_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int at;
    bit got_g;
    bit saw_fail;
    adv(3);
    // R1 during reset
    chk(claim_no == 1'b1 && !grant_o && !fail_o, "R1 in reset", {claim_no, grant_o, fail_o}, 3'b100);
    rst_ni = 1'b1;
    adv(1);
    chk(claim_no == 1'b1 && !grant_o && !fail_o, "R1 after reset", {claim_no, grant_o, fail_o}, 3'b100);

    // table walk: R3 free bus, R6 deadline on every contention pattern (R4 any bit low)
    for (int v = 0; v < 5; v++) begin
      peer_claim_ni = VECS[v].peers;
      adv(4);
      req_i = 1'b1;
      at = 0;
      got_g = 1'b0;
      for (int i = 1; i <= 200; i++) begin
        @(posedge clk);
        #1;
        req_i = 1'b0;
        if (grant_o || fail_o) begin
          at = i;
          got_g = grant_o;
          break;
        end
      end
      chk(got_g == VECS[v].exp_grant, "R3/R4 outcome", got_g, VECS[v].exp_grant);
      chk(at == int'(VECS[v].exp_at), "R3/R6 latency", at, VECS[v].exp_at);
      if (got_g) begin
        chk(claim_no == 1'b0, "R3 claim held", claim_no, 0);
        do_release();
        chk(claim_no && !grant_o && !fail_o, "R8 release", {claim_no, grant_o, fail_o}, 3'b100);
      end else begin
        chk(claim_no == 1'b1 && !grant_o, "R6 claim dropped", claim_no, 1);
        adv(1);
        chk(fail_o == 1'b0, "R6 single pulse", fail_o, 0);
      end
      peer_claim_ni = '1;
    end

    // R2 claim at accepting edge, no early grant; R9 request while owned
    adv(4);
    start_req();
    chk(claim_no == 1'b0 && !grant_o, "R2 claim asserted", {claim_no, grant_o}, 2'b00);
    adv(SETT - 1);
    chk(grant_o == 1'b0, "R2 no grant during settle", grant_o, 0);
    adv(1);
    chk(grant_o == 1'b1, "R3 grant after settle", grant_o, 1);
    req_i = 1'b1;
    adv(1);
    req_i = 1'b0;
    adv(1);
    chk(grant_o && !claim_no && !fail_o, "R9 request ignored", {grant_o, claim_no, fail_o}, 3'b100);
    do_release();

    // R4 contention clears during hold
    peer_claim_ni = 3'b110;
    adv(4);
    start_req();
    adv(6);
    peer_claim_ni = 3'b111;
    adv(7);
    chk(!grant_o && !claim_no, "R4 still holding", {grant_o, claim_no}, 2'b00);
    adv(1);
    chk(grant_o == 1'b1, "R4 grant after hold", grant_o, 1);
    do_release();

    // R5 back-off releases claim then restarts
    peer_claim_ni = 3'b110;
    adv(4);
    start_req();
    adv(SETT + HOLD);
    chk(claim_no == 1'b1 && !grant_o, "R5 backoff released", claim_no, 1);
    adv(BACK - 1);
    chk(claim_no == 1'b1, "R5 backoff length", claim_no, 1);
    adv(1);
    chk(claim_no == 1'b0, "R5 claim reasserted", claim_no, 0);
    peer_claim_ni = 3'b111;
    adv(SETT - 1);
    chk(grant_o == 1'b0, "R5 second settle", grant_o, 0);
    adv(1);
    chk(grant_o == 1'b1, "R5 grant on retry", grant_o, 1);
    do_release();

    // R7 late change is not seen in time
    adv(4);
    start_req();
    adv(2);
    peer_claim_ni = 3'b110;
    adv(2);
    chk(grant_o == 1'b1, "R7 late change unseen", grant_o, 1);
    do_release();
    peer_claim_ni = 3'b111;
    adv(4);

    // R7 change two edges earlier is seen; R8 abort during hold
    start_req();
    adv(1);
    peer_claim_ni = 3'b110;
    adv(3);
    chk(!grant_o && !claim_no, "R7 early change seen", {grant_o, claim_no}, 2'b00);
    do_release();
    chk(claim_no && !grant_o && !fail_o, "R8 abort attempt", {claim_no, grant_o, fail_o}, 3'b100);
    saw_fail = 1'b0;
    for (int i = 0; i < DEAD + 10; i++) begin
      adv(1);
      if (fail_o || !claim_no) saw_fail = 1'b1;
    end
    chk(!saw_fail, "R8 no fail after abort", saw_fail, 0);

    done = 1'b1;
    summary();
  end
endmodule